// File: doc/BRIEF.md
# Integer ALU slice with chain-derived flags

This block is a purely combinational arithmetic/logic slice that works on 8-, 16- or 32-bit operands. It performs addition, addition with incoming carry, bitwise AND, and compare. For each operation it returns a result and six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. A surrounding datapath supplies the two operands, a size code, an opcode and the current carry flag, and it stores whichever flags it needs.

The overflow and auxiliary-carry flags do not come from taps inside an adder. After the raw sum or difference is formed, a per-bit carry vector (for addition) or borrow vector (for compare) is rebuilt from the two operands and the result. Overflow is the exclusive-OR of the two highest bits of that vector at the selected width. Auxiliary carry is bit 3 of the vector. Operands are zero-extended from the selected width before use, and result bits above that width are driven low.

Top module: `alu_cc_top`

## Requirements
- R1: Opcode 00 (add) returns (a + b) mod 2^n, where n is the selected width. CF is the carry out of bit n-1.
- R2: Opcode 01 (add with carry) adds one more when cin_i is 1. Opcode 00 gives the same result and flags whatever the value of cin_i.
- R3: Opcode 10 (AND) returns a AND b and forces CF, OF and AF to 0.
- R4: Opcode 11 (compare) returns operand a, zero-extended from the selected width. Its flags describe a - b, and CF is set exactly when a < b unsigned.
- R5: OF is the XOR of carry (or borrow) bits n-1 and n-2, which is signed overflow of the selected operation.
- R6: AF is the carry (or borrow) out of bit 3 at every width.
- R7: PF is 1 when bits 7..0 of the computed value hold an even number of ones.
- R8: ZF is 1 when the computed value is zero within the selected width. SF is its bit n-1.
- R9: Size code 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. Result bits above the selected width are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | DW | first operand (destination) |
| opb_i | input | DW | second operand (source) |
| size_i | input | 2 | operand size code |
| op_i | input | 2 | operation code |
| cin_i | input | 1 | incoming carry flag |
| res_o | output | DW | result |
| cf_o | output | 1 | carry / borrow flag |
| pf_o | output | 1 | parity flag |
| af_o | output | 1 | auxiliary carry flag |
| zf_o | output | 1 | zero flag |
| sf_o | output | 1 | sign flag |
| of_o | output | 1 | overflow flag |

## Verification
Random operands seldom land exactly on the signed-overflow boundary, on an even carry into bit 4, or on a result that wraps to zero, so the chain bits at n-2, n-1 and 3 are hard to steer from the ports. For each width the stimulus drives the largest positive value plus one, the most negative value minus one, and all-ones plus one, in both add and compare form, together with the carry-in cases. The bench recomputes every flag with an explicit bit-by-bit ripple model. It also runs thousands of random vectors that cover all four size codes.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_AND = 2'd2,
    OP_CMP = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } alu_flags_t;

endpackage

// File: rtl/alu_cc_width.sv
module alu_cc_width #(
  parameter int unsigned DW  = 32,
  parameter int unsigned NSZ = 3
) (
  input  logic [1:0]     size_i,
  output logic [NSZ-1:0] sel_o,
  output logic [DW-1:0]  mask_o
);

  logic [1:0]    code;
  logic [DW-1:0] mk [NSZ];

  // codes past the widest supported size fold onto the widest
  always_comb begin
    if (int'(size_i) >= int'(NSZ)) code = 2'(NSZ - 1);
    else                           code = size_i;
  end

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int unsigned W = 8 << k;
    localparam logic [DW:0] FULL = ((DW+1)'(1) << W) - (DW+1)'(1);
    assign sel_o[k] = (code == 2'(k));
    assign mk[k]    = FULL[DW-1:0];
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < int'(NSZ); k++) begin
      if (sel_o[k]) mask_o = mask_o | mk[k];
    end
  end

endmodule

// File: rtl/alu_cc_arith.sv
module alu_cc_arith
  import alu_cc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  input  logic          cin_i,
  output logic [DW:0]   raw_o,
  output logic          sub_o
);

  logic cadd;

  always_comb begin
    cadd  = (op_i == OP_ADC) && cin_i;
    sub_o = (op_i == OP_CMP);
    unique case (op_i)
      OP_ADD, OP_ADC: raw_o = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cadd};
      OP_AND:         raw_o = {1'b0, a_i & b_i};
      default:        raw_o = {1'b0, a_i} - {1'b0, b_i};
    endcase
  end

endmodule

// File: rtl/alu_cc_chain.sv
module alu_cc_chain #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  input  logic          sub_i,
  output logic [DW-1:0] chain_o
);

  logic [DW-1:0] carry_v;
  logic [DW-1:0] borrow_v;

  // a bit generates, or propagates when the result bit came out low
  assign carry_v  = (a_i & b_i) | (~r_i & (a_i | b_i));
  // a bit borrows when a=0,b=1, or propagates when the result bit came out high
  assign borrow_v = (~a_i & b_i) | (r_i & (~a_i | b_i));
  assign chain_o  = sub_i ? borrow_v : carry_v;

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
  import alu_cc_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned NSZ = 3
) (
  input  logic [NSZ-1:0] sel_i,
  input  alu_op_e        op_i,
  input  logic [DW:0]    raw_i,
  input  logic [DW-1:0]  r_i,
  input  logic [DW-1:0]  chain_i,
  output alu_flags_t     fl_o
);

  logic [NSZ-1:0] co_v;
  logic [NSZ-1:0] of_v;
  logic [NSZ-1:0] sf_v;
  logic [NSZ-1:0] bo_v;

  for (genvar k = 0; k < NSZ; k++) begin : g_tap
    localparam int unsigned W = 8 << k;
    assign co_v[k] = sel_i[k] & raw_i[W];
    assign of_v[k] = sel_i[k] & (chain_i[W-1] ^ chain_i[W-2]);
    assign sf_v[k] = sel_i[k] & r_i[W-1];
    assign bo_v[k] = sel_i[k] & chain_i[W-1];
  end

  always_comb begin
    fl_o.zf = (r_i == '0);
    fl_o.sf = |sf_v;
    fl_o.pf = ~^r_i[7:0];
    unique case (op_i)
      OP_AND: begin
        fl_o.cf = 1'b0;
        fl_o.of = 1'b0;
        fl_o.af = 1'b0;
      end
      OP_CMP: begin
        fl_o.cf = |bo_v;
        fl_o.of = |of_v;
        fl_o.af = chain_i[3];
      end
      default: begin
        fl_o.cf = |co_v;
        fl_o.of = |of_v;
        fl_o.af = chain_i[3];
      end
    endcase
  end

  always_comb begin
    p_one_size_r9: assert ($onehot(sel_i))
      else $error("size select not one-hot");
    p_logic_quiet_r3: assert (!(op_i == OP_AND && (fl_o.cf || fl_o.of || fl_o.af)))
      else $error("AND left an arithmetic flag set");
  end

endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
  import alu_cc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    op_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          pf_o,
  output logic          af_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          of_o
);

  localparam int unsigned NSZ = $clog2(DW / 8) + 1;

  alu_op_e        op;
  logic [NSZ-1:0] sel;
  logic [DW-1:0]  mask;
  logic [DW-1:0]  am, bm, rm, chain;
  logic [DW:0]    raw;
  logic           sub;
  alu_flags_t     fl;

  assign op = alu_op_e'(op_i);

  alu_cc_width #(.DW(DW), .NSZ(NSZ)) u_width (
    .size_i (size_i),
    .sel_o  (sel),
    .mask_o (mask)
  );

  assign am = opa_i & mask;
  assign bm = opb_i & mask;

  alu_cc_arith #(.DW(DW)) u_arith (
    .a_i   (am),
    .b_i   (bm),
    .op_i  (op),
    .cin_i (cin_i),
    .raw_o (raw),
    .sub_o (sub)
  );

  assign rm = raw[DW-1:0] & mask;

  alu_cc_chain #(.DW(DW)) u_chain (
    .a_i     (am),
    .b_i     (bm),
    .r_i     (rm),
    .sub_i   (sub),
    .chain_o (chain)
  );

  alu_cc_flags #(.DW(DW), .NSZ(NSZ)) u_flags (
    .sel_i   (sel),
    .op_i    (op),
    .raw_i   (raw),
    .r_i     (rm),
    .chain_i (chain),
    .fl_o    (fl)
  );

  assign res_o = (op == OP_CMP) ? am : rm;
  assign cf_o  = fl.cf;
  assign pf_o  = fl.pf;
  assign af_o  = fl.af;
  assign zf_o  = fl.zf;
  assign sf_o  = fl.sf;
  assign of_o  = fl.of;

  function automatic logic top_bit(input logic [DW-1:0] v, input logic [1:0] c);
    case (c)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[DW-1];
    endcase
  endfunction

  always_comb begin
    p_byte_upper_r9: assert (!(size_i == 2'd0 && res_o[DW-1:8] != '0))
      else $error("bits above byte width not cleared");
    p_cmp_keeps_a_r4: assert (!(op_i == 2'd3 && res_o[7:0] != opa_i[7:0]))
      else $error("compare altered the destination");
    p_zero_flag_r8: assert (op_i == 2'd3 || zf_o == (res_o == '0))
      else $error("zero flag disagrees with result");
    p_parity_r7: assert (op_i == 2'd3 || pf_o == ~^res_o[7:0])
      else $error("parity flag disagrees with low byte");
    p_no_overflow_r5: assert (!(op_i[1] == 1'b0 && of_o &&
                               (top_bit(opa_i, size_i) != top_bit(opb_i, size_i) ||
                                top_bit(res_o, size_i) == top_bit(opa_i, size_i))))
      else $error("overflow without sign change of like-signed operands");
  end

endmodule

// File: tb/test_alu_cc_top.sv
module test_alu_cc_top;

  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [1:0]  size, op;
  logic        cin;
  logic [31:0] res;
  logic        cf, pf, af, zf, sf, of;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  alu_cc_top #(.DW(32)) i_alu_cc_top (
    .opa_i (opa), .opb_i (opb), .size_i (size), .op_i (op), .cin_i (cin),
    .res_o (res), .cf_o (cf), .pf_o (pf), .af_o (af), .zf_o (zf),
    .sf_o (sf), .of_o (of)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h exp %h (op=%0d size=%0d a=%h b=%h cin=%0d)",
               tag, what, got, exp, op, size, opa, opb, cin);
    end
  endtask

  // bitwise ripple reference
  task automatic ref_op(input int o, input int s, input logic [31:0] a, input logic [31:0] b,
                        input logic ci, output logic [31:0] r, output logic [5:0] f);
    int n;
    logic [31:0] m, am, bm, rr, ch;
    logic c;
    n  = (s >= 2) ? 32 : (8 << s);
    m  = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    am = a & m; bm = b & m; rr = '0; ch = '0;
    c  = (o == 1) ? ci : 1'b0;
    for (int i = 0; i < n; i++) begin
      if (o == 3) begin
        int d;
        d = int'(am[i]) - int'(bm[i]) - int'(c);
        rr[i] = d[0]; c = (d < 0);
      end else begin
        int t;
        t = int'(am[i]) + int'(bm[i]) + int'(c);
        rr[i] = t[0]; c = (t > 1);
      end
      ch[i] = c;
    end
    if (o == 2) rr = am & bm;
    // f = {cf,pf,af,zf,sf,of}
    f[4] = ~^rr[7:0];
    f[2] = (rr == 0);
    f[1] = rr[n-1];
    if (o == 2) begin f[5] = 0; f[3] = 0; f[0] = 0; end
    else begin f[5] = ch[n-1]; f[3] = ch[3]; f[0] = ch[n-1] ^ ch[n-2]; end
    r = (o == 3) ? am : rr;
  endtask

  task automatic run(input int o, input int s, input logic [31:0] a, input logic [31:0] b, input logic ci);
    logic [31:0] er;
    logic [5:0]  ef;
    string rt, ct;
    @(posedge clk);
    #2;
    op = 2'(o); size = 2'(s); opa = a; opb = b; cin = ci;
    @(negedge clk);
    ref_op(o, s, a, b, ci, er, ef);
    case (o)
      0: rt = ci ? "R2" : "R1";
      1: rt = "R2";
      2: rt = "R3";
      default: rt = "R4";
    endcase
    if (s == 3) rt = {rt, "/R9"};
    ct = (o == 3) ? "R4" : ((o == 2) ? "R3" : "R1");
    chk(rt,   "result", res, er);
    chk(ct,   "cf", {31'd0, cf}, {31'd0, ef[5]});
    chk("R7", "pf", {31'd0, pf}, {31'd0, ef[4]});
    chk("R6", "af", {31'd0, af}, {31'd0, ef[3]});
    chk("R8", "zf", {31'd0, zf}, {31'd0, ef[2]});
    chk("R8", "sf", {31'd0, sf}, {31'd0, ef[1]});
    chk("R5", "of", {31'd0, of}, {31'd0, ef[0]});
  endtask

  initial begin
    opa = '0; opb = '0; size = '0; op = '0; cin = 1'b0;
    // idle state with all-zero inputs
    @(negedge clk);
    chk("R8", "idle zf", {31'd0, zf}, 32'd1);
    chk("R7", "idle pf", {31'd0, pf}, 32'd1);
    chk("R9", "idle result", res, 32'd0);

    for (int s = 0; s < 3; s++) begin
      logic [31:0] m, mp, mn;
      m  = (s == 2) ? 32'hFFFF_FFFF : ((32'd1 << (8 << s)) - 32'd1);
      mp = m >> 1;
      mn = mp + 32'd1;
      run(0, s, mp, 32'd1, 1'b0);   // R5 positive overflow
      run(3, s, mn, 32'd1, 1'b0);   // R5 compare overflow
      run(0, s, m,  32'd1, 1'b0);   // R1 wrap to zero
      run(0, s, m,  32'd1, 1'b1);   // R2 cin ignored
      run(1, s, m,  32'd0, 1'b1);   // R2 carry-in ripples
      run(1, s, mp, 32'd0, 1'b1);   // R2/R5
      run(3, s, 32'd0, 32'd1, 1'b0);  // R4 borrow
      run(3, s, 32'd5, 32'd5, 1'b1);  // R4 equal
      run(2, s, m,  32'hA5A5_A5A5, 1'b1); // R3
      run(0, s, 32'h0000_0008, 32'h0000_0008, 1'b0); // R6
      run(3, s, 32'h0000_0010, 32'h0000_0001, 1'b0); // R6 borrow
      run(0, s, 32'hFFFF_FF00, 32'hFFFF_FF00, 1'b0); // R9 upper bits
    end
    run(0, 3, 32'h7FFF_FFFF, 32'd1, 1'b0);  // R9 code 11 as dword
    run(3, 3, 32'h8000_0000, 32'd1, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      run(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          $urandom(), $urandom(), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule